// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Masked Page Match

The block is a small, fully associative translation buffer that software controls. Software writes each slot directly at an index it chooses. It can search the table with a probe, read any slot back as packed words, and clear the whole table with a single flush. A lookup takes a virtual address and an address-space identifier and returns the matching slot together with its two packed frame halves. A match ignores the page-number bits that the slot's size mask covers. A slot whose global bit is set answers to every address space.

Alongside the translation, the block flags addresses in a fixed uncacheable region and keeps a round-robin replacement pointer that software can read and advance. It also counts hits, misses and accesses, with read and write traffic kept apart. All lookup, probe and read results are registered and appear one clock after the request.

Top module: `stlb_top`

## Requirements
- R1: A slot matches a page number when the request page number and the stored page number are equal in every bit where the slot's mask is 0. Bits where the mask is 1 are ignored.
- R2: A slot matches only if its global bit is 1 or its stored address-space identifier equals the request's identifier.
- R3: A slot takes part in lookup and probe only while at least one of its two valid bits is 1.
- R4: When several slots match, the slot with the lowest index is reported.
- R5: One clock after `lk_req`, exactly one of `lk_hit` and `lk_miss` is 1. `lk_idx` gives the winning slot, or 0 on a miss. Neither flag is 1 in a cycle that follows no request.
- R6: One clock after `pr_req`, `pr_done` is 1. `pr_idx` holds the matching index with a 0 top bit, or all ones (meaning -1) when no slot matches.
- R7: A write with `wr_idx` below ENTRIES replaces every field of that slot. A write with `wr_idx` at or above ENTRIES changes nothing.
- R8: A packed frame half holds the PFN at bit 6 and up, the cache attribute at bits 5:3, dirty at bit 2, valid at bit 1 and the global bit at bit 0. The tag word holds the page number from bit 11 up and the identifier in the low bits. The mask word is the mask shifted left by 11. A lookup that misses returns zero frame words.
- R9: `lk_uncached` is 1 one clock after a lookup whose address has both bit 31 and bit 29 set, whether the lookup hits or misses.
- R10: A read with `rd_from_ptr`=1 returns the slot at the replacement pointer. If `rd_advance` is also 1, the pointer then steps by one and wraps from ENTRIES-1 to 0. In any other case the pointer does not move.
- R11: Reset and `flush` both clear every slot and set the pointer to 0. A flush wins over a write or an advance in the same cycle.
- R12: Read and write lookups each have their own hit, miss and access counters. The total counters equal the sums of the read and write counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is for a store (1) or a load (0) |
| lk_va | input | VA_W | Lookup virtual address; page number is the top VPN_W bits |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit pulse |
| lk_miss | output | 1 | Lookup miss pulse |
| lk_idx | output | IDX_W | Winning slot index |
| lk_even | output | FRAME_W | Packed even frame half of the winner |
| lk_odd | output | FRAME_W | Packed odd frame half of the winner |
| lk_uncached | output | 1 | Address falls in the uncacheable region |
| pr_req | input | 1 | Probe request |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe identifier |
| pr_done | output | 1 | Probe result valid pulse |
| pr_hit | output | 1 | Probe found a slot |
| pr_idx | output | IDX_W+1 | Probe index, all ones on a miss |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | WIDX_W | Write slot index |
| wr_mask | input | VPN_W | Page size mask |
| wr_vpn | input | VPN_W | Page number |
| wr_asid | input | ASID_W | Identifier |
| wr_g | input | 1 | Global bit |
| wr_pfn0 | input | PFN_W | Even half frame number |
| wr_ca0 | input | CA_W | Even half cache attribute |
| wr_d0 | input | 1 | Even half dirty |
| wr_v0 | input | 1 | Even half valid |
| wr_pfn1 | input | PFN_W | Odd half frame number |
| wr_ca1 | input | CA_W | Odd half cache attribute |
| wr_d1 | input | 1 | Odd half dirty |
| wr_v1 | input | 1 | Odd half valid |
| rd_en | input | 1 | Slot read strobe |
| rd_from_ptr | input | 1 | Read the replacement-pointer slot instead of rd_idx |
| rd_advance | input | 1 | Step the pointer after a pointer read |
| rd_idx | input | IDX_W | Read slot index |
| rd_valid | output | 1 | Read data valid pulse |
| rd_mask_word | output | TAG_W | Packed mask word |
| rd_tag_word | output | TAG_W | Packed page number and identifier |
| rd_even | output | FRAME_W | Packed even frame half |
| rd_odd | output | FRAME_W | Packed odd frame half |
| flush | input | 1 | Clear the whole table |
| repl_ptr | output | IDX_W | Replacement pointer |
| cnt_rd_hit | output | CNT_W | Load lookup hits |
| cnt_rd_miss | output | CNT_W | Load lookup misses |
| cnt_rd_acc | output | CNT_W | Load lookups |
| cnt_wr_hit | output | CNT_W | Store lookup hits |
| cnt_wr_miss | output | CNT_W | Store lookup misses |
| cnt_wr_acc | output | CNT_W | Store lookups |
| cnt_hit | output | CNT_W | All hits |
| cnt_miss | output | CNT_W | All misses |
| cnt_acc | output | CNT_W | All lookups |

## Verification
The lookup path is driven with a hand-built table in which each request separates one matching rule from the others. Masked bits that differ still hit. A different identifier misses unless the slot is global. A slot with both valid bits clear never answers. A duplicate page number shows which index wins. Uncacheable addresses are tried both on hits and on misses, which keeps the region flag apart from the match result. A long mixed phase then draws from a small page and identifier space so that overlapping masks, out-of-range writes, pointer wraps and flushes collide in the same cycles.

// File: rtl/stlb_pkg.sv
`timescale 1ns/1ps
package stlb_pkg;
  // Bit offset of the page number inside the tag and mask readout words.
  localparam int TAG_SHIFT = 11;

  typedef enum logic {
    SRC_INDEX   = 1'b0,
    SRC_POINTER = 1'b1
  } rd_src_e;
endpackage

// File: rtl/stlb_store.sv
`timescale 1ns/1ps
module stlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int HALF_W  = 29,
  parameter int WIDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [HALF_W-1:0] wr_even,
  input  logic [HALF_W-1:0] wr_odd,
  output logic [VPN_W-1:0]  e_mask [ENTRIES],
  output logic [VPN_W-1:0]  e_vpn  [ENTRIES],
  output logic [ASID_W-1:0] e_asid [ENTRIES],
  output logic [ENTRIES-1:0] e_g,
  output logic [HALF_W-1:0] e_even [ENTRIES],
  output logic [HALF_W-1:0] e_odd  [ENTRIES],
  output logic [ENTRIES-1:0] e_live
);
  // Slot layout, low to high: odd half, even half, global, asid, vpn, mask.
  localparam int ENT_W  = 2*VPN_W + ASID_W + 1 + 2*HALF_W;
  localparam int O_EVEN = HALF_W;
  localparam int O_G    = 2*HALF_W;
  localparam int O_ASID = O_G + 1;
  localparam int O_VPN  = O_ASID + ASID_W;
  localparam int O_MASK = O_VPN + VPN_W;

  logic [ENT_W-1:0] wr_word;
  assign wr_word = {wr_mask, wr_vpn, wr_asid, wr_g, wr_even, wr_odd};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic [ENT_W-1:0] slot_q, slot_d;
    logic             sel, slot_en;

    assign sel     = wr_en && (wr_idx == WIDX_W'(i));
    assign slot_en = flush || sel;

    always_comb begin
      slot_d = slot_q;
      if (flush)    slot_d = '0;
      else if (sel) slot_d = wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    assign e_odd[i]  = slot_q[HALF_W-1:0];
    assign e_even[i] = slot_q[O_EVEN +: HALF_W];
    assign e_g[i]    = slot_q[O_G];
    assign e_asid[i] = slot_q[O_ASID +: ASID_W];
    assign e_vpn[i]  = slot_q[O_VPN +: VPN_W];
    assign e_mask[i] = slot_q[O_MASK +: VPN_W];
    // Valid bits sit at bit 0 of each half.
    assign e_live[i] = slot_q[0] | slot_q[O_EVEN];
  end

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_live == '0));

  a_r7_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && (wr_idx >= WIDX_W'(ENTRIES))) |=> $stable(e_live));
endmodule

// File: rtl/stlb_match.sv
`timescale 1ns/1ps
module stlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic [VPN_W-1:0]   e_mask [ENTRIES],
  input  logic [VPN_W-1:0]   e_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  e_asid [ENTRIES],
  input  logic [ENTRIES-1:0] e_g,
  input  logic [ENTRIES-1:0] e_live,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] m;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic page_eq, space_eq;
    assign page_eq  = (((req_vpn ^ e_vpn[i]) & ~e_mask[i]) == '0);
    assign space_eq = e_g[i] || (req_asid == e_asid[i]);
    assign m[i]     = e_live[i] && page_eq && space_eq;
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit = |m;
    idx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (m[k]) idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/stlb_stats.sv
`timescale 1ns/1ps
module stlb_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_write,
  input  logic             ev_hit,
  output logic [CNT_W-1:0] rd_hit,
  output logic [CNT_W-1:0] rd_miss,
  output logic [CNT_W-1:0] rd_acc,
  output logic [CNT_W-1:0] wr_hit,
  output logic [CNT_W-1:0] wr_miss,
  output logic [CNT_W-1:0] wr_acc,
  output logic [CNT_W-1:0] tot_hit,
  output logic [CNT_W-1:0] tot_miss,
  output logic [CNT_W-1:0] tot_acc
);
  logic rd_ev, wr_ev;
  logic [CNT_W-1:0] rh_d, rm_d, ra_d, wh_d, wm_d, wa_d;

  assign rd_ev = ev_valid && !ev_write;
  assign wr_ev = ev_valid &&  ev_write;

  always_comb begin
    ra_d = rd_acc  + CNT_W'(1);
    rh_d = rd_hit  + CNT_W'(1);
    rm_d = rd_miss + CNT_W'(1);
    wa_d = wr_acc  + CNT_W'(1);
    wh_d = wr_hit  + CNT_W'(1);
    wm_d = wr_miss + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_acc <= '0; rd_hit <= '0; rd_miss <= '0;
      wr_acc <= '0; wr_hit <= '0; wr_miss <= '0;
    end else begin
      if (rd_ev)            rd_acc  <= ra_d;
      if (rd_ev &&  ev_hit) rd_hit  <= rh_d;
      if (rd_ev && !ev_hit) rd_miss <= rm_d;
      if (wr_ev)            wr_acc  <= wa_d;
      if (wr_ev &&  ev_hit) wr_hit  <= wh_d;
      if (wr_ev && !ev_hit) wr_miss <= wm_d;
    end
  end

  assign tot_hit  = rd_hit  + wr_hit;
  assign tot_miss = rd_miss + wr_miss;
  assign tot_acc  = rd_acc  + wr_acc;

  a_r12_load_access_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> (rd_acc == $past(rd_acc) + CNT_W'(1)));

  a_r12_store_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && ev_hit) |=> (wr_hit == $past(wr_hit) + CNT_W'(1)));

  a_r12_idle_total_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(tot_acc));
endmodule

// File: rtl/stlb_top.sv
`timescale 1ns/1ps
module stlb_top #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 24,
  parameter int CA_W    = 3,
  parameter int WIDX_W  = 4,
  parameter int CNT_W   = 16,
  parameter logic [VA_W-1:0] UC_PATTERN = 32'hA000_0000,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int HALF_W  = PFN_W + CA_W + 2,
  localparam int FRAME_W = HALF_W + 1,
  localparam int TAG_W   = VPN_W + stlb_pkg::TAG_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic               lk_wr,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic               lk_miss,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [FRAME_W-1:0] lk_even,
  output logic [FRAME_W-1:0] lk_odd,
  output logic               lk_uncached,
  input  logic               pr_req,
  input  logic [VPN_W-1:0]   pr_vpn,
  input  logic [ASID_W-1:0]  pr_asid,
  output logic               pr_done,
  output logic               pr_hit,
  output logic [IDX_W:0]     pr_idx,
  input  logic               wr_en,
  input  logic [WIDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]   wr_mask,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic               wr_g,
  input  logic [PFN_W-1:0]   wr_pfn0,
  input  logic [CA_W-1:0]    wr_ca0,
  input  logic               wr_d0,
  input  logic               wr_v0,
  input  logic [PFN_W-1:0]   wr_pfn1,
  input  logic [CA_W-1:0]    wr_ca1,
  input  logic               wr_d1,
  input  logic               wr_v1,
  input  logic               rd_en,
  input  logic               rd_from_ptr,
  input  logic               rd_advance,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_mask_word,
  output logic [TAG_W-1:0]   rd_tag_word,
  output logic [FRAME_W-1:0] rd_even,
  output logic [FRAME_W-1:0] rd_odd,
  input  logic               flush,
  output logic [IDX_W-1:0]   repl_ptr,
  output logic [CNT_W-1:0]   cnt_rd_hit,
  output logic [CNT_W-1:0]   cnt_rd_miss,
  output logic [CNT_W-1:0]   cnt_rd_acc,
  output logic [CNT_W-1:0]   cnt_wr_hit,
  output logic [CNT_W-1:0]   cnt_wr_miss,
  output logic [CNT_W-1:0]   cnt_wr_acc,
  output logic [CNT_W-1:0]   cnt_hit,
  output logic [CNT_W-1:0]   cnt_miss,
  output logic [CNT_W-1:0]   cnt_acc
);
  import stlb_pkg::*;

  // Reset: asserted asynchronously, released on the second clock edge.
  logic rs_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_i   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_i   <= rs_meta;
    end
  end

  // Table storage.
  logic [VPN_W-1:0]   e_mask [ENTRIES];
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [ENTRIES-1:0] e_g, e_live;
  logic [HALF_W-1:0]  e_even [ENTRIES];
  logic [HALF_W-1:0]  e_odd  [ENTRIES];

  stlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
    .HALF_W(HALF_W), .WIDX_W(WIDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_i), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_even({wr_pfn0, wr_ca0, wr_d0, wr_v0}),
    .wr_odd ({wr_pfn1, wr_ca1, wr_d1, wr_v1}),
    .e_mask(e_mask), .e_vpn(e_vpn), .e_asid(e_asid), .e_g(e_g),
    .e_even(e_even), .e_odd(e_odd), .e_live(e_live)
  );

  // Two comparator banks: translation lookup and probe.
  logic             lk_m_hit, pr_m_hit;
  logic [IDX_W-1:0] lk_m_idx, pr_m_idx;

  stlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .req_vpn(lk_va[VA_W-1 -: VPN_W]), .req_asid(lk_asid),
    .e_mask(e_mask), .e_vpn(e_vpn), .e_asid(e_asid), .e_g(e_g), .e_live(e_live),
    .hit(lk_m_hit), .idx(lk_m_idx)
  );

  stlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr_match (
    .req_vpn(pr_vpn), .req_asid(pr_asid),
    .e_mask(e_mask), .e_vpn(e_vpn), .e_asid(e_asid), .e_g(e_g), .e_live(e_live),
    .hit(pr_m_hit), .idx(pr_m_idx)
  );

  stlb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_i),
    .ev_valid(lk_req), .ev_write(lk_wr), .ev_hit(lk_m_hit),
    .rd_hit(cnt_rd_hit), .rd_miss(cnt_rd_miss), .rd_acc(cnt_rd_acc),
    .wr_hit(cnt_wr_hit), .wr_miss(cnt_wr_miss), .wr_acc(cnt_wr_acc),
    .tot_hit(cnt_hit), .tot_miss(cnt_miss), .tot_acc(cnt_acc)
  );

  // Lookup result next state.
  logic               lk_hit_d, lk_miss_d, lk_uc_d;
  logic [IDX_W-1:0]   lk_idx_d;
  logic [FRAME_W-1:0] lk_even_d, lk_odd_d;

  always_comb begin
    lk_hit_d  = lk_req &&  lk_m_hit;
    lk_miss_d = lk_req && !lk_m_hit;
    lk_uc_d   = lk_req && ((lk_va & UC_PATTERN) == UC_PATTERN);
    lk_idx_d  = lk_m_hit ? lk_m_idx : '0;
    lk_even_d = lk_m_hit ? {e_even[lk_m_idx], e_g[lk_m_idx]} : '0;
    lk_odd_d  = lk_m_hit ? {e_odd[lk_m_idx],  e_g[lk_m_idx]} : '0;
  end

  // Probe result next state.
  logic           pr_hit_d;
  logic [IDX_W:0] pr_idx_d;

  always_comb begin
    pr_hit_d = pr_req && pr_m_hit;
    pr_idx_d = pr_m_hit ? {1'b0, pr_m_idx} : '1;
  end

  // Slot readout and replacement pointer.
  rd_src_e            rd_src;
  logic [IDX_W-1:0]   rd_sel, ptr_d;
  logic               ptr_step, ptr_en;
  logic [TAG_W-1:0]   rd_mask_d, rd_tag_d;
  logic [FRAME_W-1:0] rd_even_d, rd_odd_d;

  always_comb begin
    rd_src    = rd_src_e'(rd_from_ptr);
    rd_sel    = (rd_src == SRC_POINTER) ? repl_ptr : rd_idx;
    rd_mask_d = {e_mask[rd_sel], {TAG_SHIFT{1'b0}}};
    rd_tag_d  = {e_vpn[rd_sel], {TAG_SHIFT{1'b0}}} | TAG_W'(e_asid[rd_sel]);
    rd_even_d = {e_even[rd_sel], e_g[rd_sel]};
    rd_odd_d  = {e_odd[rd_sel],  e_g[rd_sel]};
    ptr_step  = rd_en && (rd_src == SRC_POINTER) && rd_advance;
    ptr_en    = flush || ptr_step;
    if (flush)                               ptr_d = '0;
    else if (repl_ptr == IDX_W'(ENTRIES-1))  ptr_d = '0;
    else                                     ptr_d = repl_ptr + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lk_hit <= 1'b0; lk_miss <= 1'b0; lk_uncached <= 1'b0;
      lk_idx <= '0;   lk_even <= '0;   lk_odd <= '0;
      pr_done <= 1'b0; pr_hit <= 1'b0; pr_idx <= '0;
      rd_valid <= 1'b0; rd_mask_word <= '0; rd_tag_word <= '0;
      rd_even <= '0;    rd_odd <= '0;
      repl_ptr <= '0;
    end else begin
      lk_hit      <= lk_hit_d;
      lk_miss     <= lk_miss_d;
      lk_uncached <= lk_uc_d;
      if (lk_req) begin
        lk_idx  <= lk_idx_d;
        lk_even <= lk_even_d;
        lk_odd  <= lk_odd_d;
      end
      pr_done <= pr_req;
      pr_hit  <= pr_hit_d;
      if (pr_req) pr_idx <= pr_idx_d;
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_mask_word <= rd_mask_d;
        rd_tag_word  <= rd_tag_d;
        rd_even      <= rd_even_d;
        rd_odd       <= rd_odd_d;
      end
      if (ptr_en) repl_ptr <= ptr_d;
    end
  end

  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_i)
    lk_req |=> (lk_hit ^ lk_miss));

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_i)
    !lk_req |=> (!lk_hit && !lk_miss));

  a_r6_miss_code: assert property (@(posedge clk) disable iff (!rst_i)
    (pr_done && !pr_hit) |-> (&pr_idx));

  a_r9_flag_needs_request: assert property (@(posedge clk) disable iff (!rst_i)
    lk_uncached |-> $past(lk_req));

  a_r10_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_i)
    (ptr_step && !flush && (repl_ptr == IDX_W'(ENTRIES-1))) |=> (repl_ptr == '0));

  a_r10_pointer_holds: assert property (@(posedge clk) disable iff (!rst_i)
    (!flush && !(rd_en && rd_from_ptr && rd_advance)) |=> $stable(repl_ptr));

  a_r11_flush_pointer: assert property (@(posedge clk) disable iff (!rst_i)
    flush |=> (repl_ptr == '0));
endmodule

// File: tb/sim_stlb_top.sv
`timescale 1ns/1ps
module sim_stlb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk_req, lk_wr;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_hit, lk_miss, lk_uncached;
  logic [2:0]  lk_idx;
  logic [29:0] lk_even, lk_odd;
  logic        pr_req;
  logic [18:0] pr_vpn;
  logic [7:0]  pr_asid;
  logic        pr_done, pr_hit;
  logic [3:0]  pr_idx;
  logic        wr_en, wr_g, wr_d0, wr_v0, wr_d1, wr_v1;
  logic [3:0]  wr_idx;
  logic [18:0] wr_mask, wr_vpn;
  logic [7:0]  wr_asid;
  logic [23:0] wr_pfn0, wr_pfn1;
  logic [2:0]  wr_ca0, wr_ca1;
  logic        rd_en, rd_from_ptr, rd_advance, rd_valid;
  logic [2:0]  rd_idx;
  logic [29:0] rd_mask_word, rd_tag_word, rd_even, rd_odd;
  logic        flush;
  logic [2:0]  repl_ptr;
  logic [15:0] c_rh, c_rm, c_ra, c_wh, c_wm, c_wa, c_h, c_m, c_a;

  stlb_top u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_wr(lk_wr), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_idx(lk_idx), .lk_even(lk_even),
    .lk_odd(lk_odd), .lk_uncached(lk_uncached),
    .pr_req(pr_req), .pr_vpn(pr_vpn), .pr_asid(pr_asid),
    .pr_done(pr_done), .pr_hit(pr_hit), .pr_idx(pr_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_ca0(wr_ca0), .wr_d0(wr_d0), .wr_v0(wr_v0),
    .wr_pfn1(wr_pfn1), .wr_ca1(wr_ca1), .wr_d1(wr_d1), .wr_v1(wr_v1),
    .rd_en(rd_en), .rd_from_ptr(rd_from_ptr), .rd_advance(rd_advance),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_mask_word(rd_mask_word),
    .rd_tag_word(rd_tag_word), .rd_even(rd_even), .rd_odd(rd_odd),
    .flush(flush), .repl_ptr(repl_ptr),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_rd_acc(c_ra),
    .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm), .cnt_wr_acc(c_wa),
    .cnt_hit(c_h), .cnt_miss(c_m), .cnt_acc(c_a)
  );

  // Behavioural model state.
  logic [18:0] m_mask [N], m_vpn [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N], m_d0 [N], m_v0 [N], m_d1 [N], m_v1 [N];
  logic [23:0] m_pfn0 [N], m_pfn1 [N];
  logic [2:0]  m_c0 [N], m_c1 [N];
  int          m_ptr;
  int          k_rh, k_rm, k_ra, k_wh, k_wm, k_wa;

  // Expected outputs for the next sample.
  logic        x_lk_hit, x_lk_miss, x_uc, x_pr_done, x_pr_hit, x_rd_valid;
  logic [2:0]  x_lk_idx;
  logic [29:0] x_lk_even, x_lk_odd, x_rd_mask, x_rd_tag, x_rd_even, x_rd_odd;
  logic [3:0]  x_pr_idx;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [29:0] half(logic [23:0] p, logic [2:0] c, logic d, logic v, logic g);
    return (30'(p) << 6) | (30'(c) << 3) | (30'(d) << 2) | (30'(v) << 1) | 30'(g);
  endfunction

  function automatic int find(logic [18:0] vpn, logic [7:0] asid);
    for (int i = 0; i < N; i++) begin
      if ((m_v0[i] || m_v1[i]) && (((vpn ^ m_vpn[i]) & ~m_mask[i]) == 19'd0) &&
          (m_g[i] || (m_asid[i] == asid)))
        return i;
    end
    return -1;
  endfunction

  task automatic idle();
    lk_req = 0; lk_wr = 0; lk_va = '0; lk_asid = '0;
    pr_req = 0; pr_vpn = '0; pr_asid = '0;
    wr_en = 0; wr_idx = '0; wr_mask = '0; wr_vpn = '0; wr_asid = '0; wr_g = 0;
    wr_pfn0 = '0; wr_ca0 = '0; wr_d0 = 0; wr_v0 = 0;
    wr_pfn1 = '0; wr_ca1 = '0; wr_d1 = 0; wr_v1 = 0;
    rd_en = 0; rd_from_ptr = 0; rd_advance = 0; rd_idx = '0; flush = 0;
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) begin
      m_mask[i] = '0; m_vpn[i] = '0; m_asid[i] = '0; m_g[i] = 0;
      m_pfn0[i] = '0; m_c0[i] = '0; m_d0[i] = 0; m_v0[i] = 0;
      m_pfn1[i] = '0; m_c1[i] = '0; m_d1[i] = 0; m_v1[i] = 0;
    end
    m_ptr = 0;
  endtask

  // Work out next-sample outputs from the current state, then update the state.
  task automatic predict();
    int f;
    f = find(lk_va[31:13], lk_asid);
    x_lk_hit  = lk_req && (f >= 0);
    x_lk_miss = lk_req && (f < 0);
    x_uc      = lk_req && lk_va[31] && lk_va[29];
    if (lk_req) begin
      x_lk_idx  = (f >= 0) ? 3'(f) : 3'd0;
      x_lk_even = (f >= 0) ? half(m_pfn0[f], m_c0[f], m_d0[f], m_v0[f], m_g[f]) : 30'd0;
      x_lk_odd  = (f >= 0) ? half(m_pfn1[f], m_c1[f], m_d1[f], m_v1[f], m_g[f]) : 30'd0;
      if (lk_wr) begin k_wa++; if (f >= 0) k_wh++; else k_wm++; end
      else       begin k_ra++; if (f >= 0) k_rh++; else k_rm++; end
    end
    f = find(pr_vpn, pr_asid);
    x_pr_done = pr_req;
    x_pr_hit  = pr_req && (f >= 0);
    if (pr_req) x_pr_idx = (f >= 0) ? 4'(f) : 4'hF;
    x_rd_valid = rd_en;
    if (rd_en) begin
      int s;
      s = rd_from_ptr ? m_ptr : int'(rd_idx);
      x_rd_mask = 30'(m_mask[s]) << 11;
      x_rd_tag  = (30'(m_vpn[s]) << 11) | 30'(m_asid[s]);
      x_rd_even = half(m_pfn0[s], m_c0[s], m_d0[s], m_v0[s], m_g[s]);
      x_rd_odd  = half(m_pfn1[s], m_c1[s], m_d1[s], m_v1[s], m_g[s]);
    end
    if (flush) clear_model();
    else begin
      if (wr_en && (int'(wr_idx) < N)) begin
        m_mask[wr_idx] = wr_mask; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_g;
        m_pfn0[wr_idx] = wr_pfn0; m_c0[wr_idx] = wr_ca0; m_d0[wr_idx] = wr_d0; m_v0[wr_idx] = wr_v0;
        m_pfn1[wr_idx] = wr_pfn1; m_c1[wr_idx] = wr_ca1; m_d1[wr_idx] = wr_d1; m_v1[wr_idx] = wr_v1;
      end
      if (rd_en && rd_from_ptr && rd_advance) m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic compare();
    chk("R5 lk_hit",  64'(lk_hit),  64'(x_lk_hit));
    chk("R5 lk_miss", 64'(lk_miss), 64'(x_lk_miss));
    chk("R5 lk_idx",  64'(lk_idx),  64'(x_lk_idx));
    chk("R8 lk_even", 64'(lk_even), 64'(x_lk_even));
    chk("R8 lk_odd",  64'(lk_odd),  64'(x_lk_odd));
    chk("R9 lk_uncached", 64'(lk_uncached), 64'(x_uc));
    chk("R6 pr_done", 64'(pr_done), 64'(x_pr_done));
    chk("R6 pr_hit",  64'(pr_hit),  64'(x_pr_hit));
    chk("R6 pr_idx",  64'(pr_idx),  64'(x_pr_idx));
    chk("R8 rd_valid", 64'(rd_valid), 64'(x_rd_valid));
    chk("R8 rd_mask_word", 64'(rd_mask_word), 64'(x_rd_mask));
    chk("R8 rd_tag_word",  64'(rd_tag_word),  64'(x_rd_tag));
    chk("R8 rd_even", 64'(rd_even), 64'(x_rd_even));
    chk("R8 rd_odd",  64'(rd_odd),  64'(x_rd_odd));
    chk("R10 repl_ptr", 64'(repl_ptr), 64'(m_ptr));
    chk("R12 rd_hit",  64'(c_rh), 64'(16'(k_rh)));
    chk("R12 rd_miss", 64'(c_rm), 64'(16'(k_rm)));
    chk("R12 rd_acc",  64'(c_ra), 64'(16'(k_ra)));
    chk("R12 wr_hit",  64'(c_wh), 64'(16'(k_wh)));
    chk("R12 wr_miss", 64'(c_wm), 64'(16'(k_wm)));
    chk("R12 wr_acc",  64'(c_wa), 64'(16'(k_wa)));
    chk("R12 tot_hit",  64'(c_h), 64'(16'(k_rh + k_wh)));
    chk("R12 tot_miss", 64'(c_m), 64'(16'(k_rm + k_wm)));
    chk("R12 tot_acc",  64'(c_a), 64'(16'(k_ra + k_wa)));
  endtask

  task automatic cyc();
    predict();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic put(int idx, logic [18:0] msk, logic [18:0] vpn, logic [7:0] asid,
                     logic g, logic [23:0] p0, logic [2:0] c0, logic d0, logic v0,
                     logic [23:0] p1, logic [2:0] c1, logic d1, logic v1);
    wr_en = 1; wr_idx = 4'(idx); wr_mask = msk; wr_vpn = vpn; wr_asid = asid; wr_g = g;
    wr_pfn0 = p0; wr_ca0 = c0; wr_d0 = d0; wr_v0 = v0;
    wr_pfn1 = p1; wr_ca1 = c1; wr_d1 = d1; wr_v1 = v1;
    cyc();
  endtask

  task automatic look(string tag, logic [31:0] va, logic [7:0] asid, logic w,
                      logic exp_hit, logic [2:0] exp_idx);
    lk_req = 1; lk_va = va; lk_asid = asid; lk_wr = w;
    cyc();
    chk(tag, 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) chk(tag, 64'(lk_idx), 64'(exp_idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] a0, w0;
    idle();
    clear_model();
    k_rh = 0; k_rm = 0; k_ra = 0; k_wh = 0; k_wm = 0; k_wa = 0;
    x_lk_hit = 0; x_lk_miss = 0; x_uc = 0; x_lk_idx = '0; x_lk_even = '0; x_lk_odd = '0;
    x_pr_done = 0; x_pr_hit = 0; x_pr_idx = '0;
    x_rd_valid = 0; x_rd_mask = '0; x_rd_tag = '0; x_rd_even = '0; x_rd_odd = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset lk_hit", 64'(lk_hit), 64'd0);
    chk("R11 reset ptr", 64'(repl_ptr), 64'd0);
    chk("R11 reset acc", 64'(c_a), 64'd0);
    chk("R11 reset pr_done", 64'(pr_done), 64'd0);
    rst_n = 1;
    repeat (3) cyc();

    // Directed table.
    put(0, 19'h0, 19'h00010, 8'd5, 0, 24'h111, 3'd3, 1, 1, 24'h222, 3'd2, 0, 0);
    put(1, 19'h0000F, 19'h00120, 8'd7, 0, 24'h333, 3'd1, 0, 0, 24'h444, 3'd5, 1, 1);
    put(2, 19'h0, 19'h00300, 8'd9, 1, 24'h555, 3'd0, 0, 1, 24'h666, 3'd7, 1, 1);
    put(3, 19'h0, 19'h00400, 8'd1, 0, 24'h777, 3'd2, 1, 0, 24'h888, 3'd2, 1, 0);
    put(4, 19'h0, 19'h00010, 8'd5, 0, 24'h999, 3'd4, 0, 1, 24'haaa, 3'd1, 0, 1);
    put(5, 19'h000FF, 19'h00120, 8'd7, 0, 24'hbbb, 3'd6, 1, 1, 24'hccc, 3'd3, 0, 0);
    put(6, 19'h0, 19'h50000, 8'd2, 0, 24'hddd, 3'd5, 0, 0, 24'heee, 3'd4, 1, 1);

    look("R4 lowest index wins",      {19'h00010, 13'h0}, 8'd5, 0, 1, 3'd0);
    look("R2 asid mismatch misses",   {19'h00010, 13'h4}, 8'd6, 0, 0, 3'd0);
    look("R1 masked bits ignored",    {19'h0012A, 13'h0}, 8'd7, 1, 1, 3'd1);
    look("R1 unmasked bit differs",   {19'h0013A, 13'h0}, 8'd7, 0, 1, 3'd5);
    look("R1 outside all masks",      {19'h00220, 13'h0}, 8'd7, 1, 0, 3'd0);
    look("R2 global ignores asid",    {19'h00300, 13'h0}, 8'h33, 0, 1, 3'd2);
    look("R3 slot with no valid bit", {19'h00400, 13'h0}, 8'd1, 1, 0, 3'd0);
    look("R9 uncached on hit",        32'hA000_0000, 8'd2, 0, 1, 3'd6);
    chk("R9 uncached on hit", 64'(lk_uncached), 64'd1);
    look("R9 uncached on miss",       32'hE000_1234, 8'd2, 1, 0, 3'd0);
    chk("R9 uncached on miss", 64'(lk_uncached), 64'd1);
    look("R9 one bit only",           32'h8000_0000, 8'd2, 0, 0, 3'd0);
    chk("R9 one bit only", 64'(lk_uncached), 64'd0);

    // R6: probe hit and miss code.
    pr_req = 1; pr_vpn = 19'h00010; pr_asid = 8'd5; cyc();
    chk("R6 probe index", 64'(pr_idx), 64'd0);
    pr_req = 1; pr_vpn = 19'h00999; pr_asid = 8'd5; cyc();
    chk("R6 probe miss is all ones", 64'(pr_idx), 64'hF);

    // R7: out-of-range write ignored, in-range write replaces all fields.
    put(8, 19'h0, 19'h00777, 8'd1, 1, 24'h123, 3'd1, 1, 1, 24'h456, 3'd1, 1, 1);
    put(15, 19'h0, 19'h00778, 8'd1, 1, 24'h123, 3'd1, 1, 1, 24'h456, 3'd1, 1, 1);
    look("R7 out-of-range write ignored", {19'h00777, 13'h0}, 8'd1, 0, 0, 3'd0);
    for (int i = 0; i < N; i++) begin rd_en = 1; rd_idx = 3'(i); cyc(); end
    put(0, 19'h00003, 19'h01234, 8'hAB, 1, 24'hFEDCBA, 3'd6, 0, 0, 24'h0F0F0F, 3'd1, 1, 1);
    rd_en = 1; rd_idx = 3'd0; cyc();
    chk("R7 R8 tag word", 64'(rd_tag_word), 64'((30'h01234 << 11) | 30'hAB));
    chk("R7 R8 mask word", 64'(rd_mask_word), 64'(30'h3 << 11));
    chk("R7 R8 odd word", 64'(rd_odd), 64'((30'h0F0F0F << 6) | 30'h0F));
    look("R4 slot 4 after overwrite", {19'h00010, 13'h0}, 8'd5, 0, 1, 3'd4);

    // R10: pointer reads, advance, wrap, holds.
    for (int i = 0; i < 9; i++) begin rd_en = 1; rd_from_ptr = 1; rd_advance = 1; cyc(); end
    chk("R10 pointer wrapped", 64'(repl_ptr), 64'd1);
    rd_en = 1; rd_from_ptr = 1; cyc();
    chk("R10 read without advance holds", 64'(repl_ptr), 64'd1);
    rd_en = 1; rd_advance = 1; rd_idx = 3'd2; cyc();
    chk("R10 index read does not move", 64'(repl_ptr), 64'd1);

    // R12: counter deltas.
    a0 = c_a; w0 = c_wa;
    look("R12 load", {19'h00300, 13'h0}, 8'd0, 0, 1, 3'd2);
    look("R12 load", {19'h00301, 13'h0}, 8'd0, 0, 0, 3'd0);
    look("R12 store", {19'h00300, 13'h0}, 8'd0, 1, 1, 3'd2);
    chk("R12 total access delta", 64'(c_a - a0), 64'd3);
    chk("R12 store access delta", 64'(c_wa - w0), 64'd1);

    // R11: flush beats a same-cycle write and advance.
    flush = 1; rd_en = 1; rd_from_ptr = 1; rd_advance = 1;
    wr_en = 1; wr_idx = 4'd2; wr_vpn = 19'h00300; wr_g = 1; wr_v0 = 1;
    cyc();
    chk("R11 flush clears pointer", 64'(repl_ptr), 64'd0);
    look("R11 flushed slot misses", {19'h00300, 13'h0}, 8'd0, 0, 0, 3'd0);
    rd_en = 1; rd_idx = 3'd2; cyc();
    chk("R11 flushed slot reads zero", 64'(rd_tag_word), 64'd0);

    // Mixed phase over a small page and identifier space.
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      lk_req = ($urandom_range(0, 1) == 1);
      lk_wr  = ($urandom_range(0, 1) == 1);
      lk_va  = {16'h0, 3'($urandom_range(0, 7)), 13'($urandom)};
      if ($urandom_range(0, 7) == 0) lk_va[31:29] = 3'b101;
      lk_asid = 8'($urandom_range(0, 3));
      pr_req = ($urandom_range(0, 2) == 0);
      pr_vpn = 19'($urandom_range(0, 7));
      pr_asid = 8'($urandom_range(0, 3));
      if (r < 30) begin
        wr_en = 1; wr_idx = 4'($urandom_range(0, 9));
        wr_mask = 19'((1 << $urandom_range(0, 2)) - 1);
        wr_vpn = 19'($urandom_range(0, 7)); wr_asid = 8'($urandom_range(0, 3));
        wr_g = ($urandom_range(0, 4) == 0);
        wr_pfn0 = 24'($urandom); wr_ca0 = 3'($urandom); wr_d0 = 1'($urandom); wr_v0 = 1'($urandom);
        wr_pfn1 = 24'($urandom); wr_ca1 = 3'($urandom); wr_d1 = 1'($urandom); wr_v1 = 1'($urandom);
      end
      if (r >= 50) begin
        rd_en = 1; rd_from_ptr = 1'($urandom); rd_advance = 1'($urandom); rd_idx = 3'($urandom);
      end
      if ($urandom_range(0, 63) == 0) flush = 1;
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule